// File: doc/BRIEF.md
# Moving-Average Difference Pulse-Height Extractor

This block turns a stream of signed digitized detector samples into pulse amplitudes. Each accepted sample is scaled down to its upper half, and two running sums of equal window length are kept: one over the most recent scaled samples and one over the same samples after a fixed delay. Their difference is a trapezoid-like shaped signal that rises while a pulse arrives and falls back once the delayed copy catches up.

The block follows the slope of the shaped signal sample by sample. When a falling stretch turns into a rise, the last value before the turn is remembered as the valley. When a rising stretch turns into a fall, the last value before the turn is a peak, and the block reports the height of that peak above the remembered valley. Every accepted sample yields exactly one result one clock later, and the result is zero unless a peak was found on that sample. The baseline therefore follows the signal instead of being fixed, which keeps pulses on a sloping tail measurable.

Top module: `phx_pulse_height`

## Requirements
- R1: After reset, `amp_valid` is 0, `amp` is 0, and all history (stored samples, sums, slope, valley and last shaped value) is zero, so the first samples behave as if preceded by zero-valued samples.
- R2: Each sample is scaled by an arithmetic right shift of 16 bits: bits 31:16 are used as a signed 16-bit value and bits 15:0 have no effect on any output.
- R3: On every accepted sample the shaped value is the sum of the 10 most recent scaled samples (this one included) minus the sum of the 10 scaled samples accepted before those.
- R4: `amp_valid` is 1 in exactly the clock cycle that follows a cycle with `in_valid` high, and 0 otherwise.
- R5: While `amp_valid` is 0, `amp` is 0; a cycle with `in_valid` low changes no stored state.
- R6: The slope state becomes rising when the shaped value exceeds the previous one, falling when it is below it, and is kept unchanged when the two are equal.
- R7: When the slope state was falling and the shaped value now rises, the previous shaped value is stored as the valley.
- R8: When the slope state was rising and the shaped value now falls, `amp` reports the previous shaped value minus the stored valley; on every other accepted sample `amp` is 0.
- R9: A reported amplitude is never negative, and two consecutive results are never both non-zero.
- R10: Full-scale inputs of either sign do not overflow: a negative full-scale step of 30 samples followed by a positive full-scale step reports 983030.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe: `in_sample` holds a new sample this cycle |
| in_sample | input | 32 | Raw signed sample, two's complement |
| amp_valid | output | 1 | One-cycle flag: a result for the previous sample |
| amp | output | 22 | Signed pulse amplitude, zero when no peak |

## Verification
The hardest situation to reach is a peak measured against a valley far below zero, because the valley is only captured after a long falling run and the peak needs both running sums at opposite full-scale extremes at once. The bench gets there with a full-scale negative step held long enough for the delayed sum to catch up, followed by a full-scale positive step, and checks the exact amplitude. Gaps in the strobe, noisy pulse trains, plateaus that keep the slope unchanged, and a reset in mid-stream are all compared against a behavioural model on every clock.

// File: rtl/phx_pkg.sv
// Package: shared types of the pulse-height extractor.
// Assumes nothing beyond SystemVerilog 2017.
package phx_pkg;

    // Slope state of the shaped signal; FLAT only before the first change.
    typedef enum logic [1:0] {
        SLOPE_FLAT = 2'd0,
        SLOPE_UP   = 2'd1,
        SLOPE_DOWN = 2'd2
    } slope_e;

endpackage

// File: rtl/phx_delay_line.sv
// Circular delay buffer. dout presents the entry written DEPTH enables ago
// (zero after reset); on en the new value overwrites it and the pointer moves.
// Assumes DEPTH >= 1.
module phx_delay_line #(
    parameter int W     = 16,
    parameter int DEPTH = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] dout
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic signed [W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]    ptr;

    // Oldest entry, read before it is overwritten.
    assign dout = mem[ptr];

    // Write the incoming value and advance the wrapping pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (en) begin
            mem[ptr] <= din;
            ptr      <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

endmodule

// File: rtl/phx_running_sum.sv
// Running sum over the last WIN inputs. sum_nxt is the sum including the
// present input, valid combinationally while en is high.
// Assumes SUM_W >= IN_W + clog2(WIN), so the sum cannot overflow.
module phx_running_sum #(
    parameter int IN_W  = 16,
    parameter int SUM_W = 20,
    parameter int WIN   = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic signed [IN_W-1:0]  din,
    output logic signed [SUM_W-1:0] sum_nxt
);
    logic signed [IN_W-1:0]  leaving;
    logic signed [SUM_W-1:0] sum_q;

    phx_delay_line #(.W(IN_W), .DEPTH(WIN)) win_i (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en),
        .din  (din),
        .dout (leaving)
    );

    // Add the arriving value, drop the one leaving the window.
    assign sum_nxt = sum_q + SUM_W'(din) - SUM_W'(leaving);

    // Hold the sum between accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n)  sum_q <= '0;
        else if (en) sum_q <= sum_nxt;
    end

endmodule

// File: rtl/phx_slope_tracker.sv
// Follows the slope of the shaped signal, captures valleys at down-to-up
// turns and reports peak minus valley at up-to-down turns, registered.
// Assumes AMP_W >= SHP_W + 1.
module phx_slope_tracker
    import phx_pkg::*;
#(
    parameter int SHP_W = 21,
    parameter int AMP_W = 22
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic signed [SHP_W-1:0] shaped,
    output logic                    amp_valid,
    output logic signed [AMP_W-1:0] amp
);
    slope_e                  dir_q;
    logic signed [SHP_W-1:0] last_q;
    logic signed [SHP_W-1:0] valley_q;
    logic                    rising, falling, peak_hit;
    logic signed [AMP_W-1:0] amp_nxt;

    // Compare with the previous shaped value and form the amplitude.
    always_comb begin
        rising   = shaped > last_q;
        falling  = shaped < last_q;
        peak_hit = falling && (dir_q == SLOPE_UP);
        amp_nxt  = peak_hit ? (AMP_W'(last_q) - AMP_W'(valley_q)) : '0;
    end

    // Update slope, valley and history; emit one result per sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q     <= SLOPE_FLAT;
            last_q    <= '0;
            valley_q  <= '0;
            amp_valid <= 1'b0;
            amp       <= '0;
        end else if (en) begin
            amp_valid <= 1'b1;
            amp       <= amp_nxt;
            last_q    <= shaped;
            if (rising) begin
                if (dir_q == SLOPE_DOWN) valley_q <= last_q;
                dir_q <= SLOPE_UP;
            end else if (falling) begin
                dir_q <= SLOPE_DOWN;
            end
        end else begin
            amp_valid <= 1'b0;
            amp       <= '0;
        end
    end

endmodule

// File: rtl/phx_pulse_height.sv
// Top: scales samples, delays them, keeps a current and a delayed running
// sum, forms their difference and extracts pulse amplitudes from it.
// Assumes one sample per in_valid cycle; result appears one cycle later.
module phx_pulse_height #(
    parameter int SAMPLE_W = 32,
    parameter int SHIFT    = 16,
    parameter int DLY      = 10,
    parameter int WIN      = 10
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         in_valid,
    input  logic [SAMPLE_W-1:0]                          in_sample,
    output logic                                         amp_valid,
    output logic signed [SAMPLE_W-SHIFT+$clog2(WIN)+1:0] amp
);
    localparam int VAL_W = SAMPLE_W - SHIFT;
    localparam int SUM_W = VAL_W + $clog2(WIN);
    localparam int SHP_W = SUM_W + 1;
    localparam int AMP_W = SHP_W + 1;

    // Arithmetic shift of the full word, kept to the value width.
    function automatic logic signed [VAL_W-1:0] scale(input logic [SAMPLE_W-1:0] s);
        logic signed [SAMPLE_W-1:0] t;
        t = $signed(s) >>> SHIFT;
        return t[VAL_W-1:0];
    endfunction

    logic signed [VAL_W-1:0] scaled, delayed;
    logic signed [VAL_W-1:0] feed [2];
    logic signed [SUM_W-1:0] sums [2];
    logic signed [SHP_W-1:0] shaped;

    assign scaled  = scale(in_sample);
    assign feed[0] = scaled;
    assign feed[1] = delayed;

    phx_delay_line #(.W(VAL_W), .DEPTH(DLY)) dly_i (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (in_valid),
        .din  (scaled),
        .dout (delayed)
    );

    // Index 0 sums current samples, index 1 sums delayed samples.
    for (genvar g = 0; g < 2; g++) begin : g_sum
        phx_running_sum #(.IN_W(VAL_W), .SUM_W(SUM_W), .WIN(WIN)) sum_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (in_valid),
            .din    (feed[g]),
            .sum_nxt(sums[g])
        );
    end

    assign shaped = SHP_W'(sums[0]) - SHP_W'(sums[1]);

    phx_slope_tracker #(.SHP_W(SHP_W), .AMP_W(AMP_W)) trk_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (in_valid),
        .shaped   (shaped),
        .amp_valid(amp_valid),
        .amp      (amp)
    );

endmodule

// File: rtl/phx_pulse_height_chk.sv
// Checker for the pulse-height extractor, bound to the top module.
// Watches only the ports.
module phx_pulse_height_chk #(
    parameter int AMP_W = 22
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    out_valid,
    input logic signed [AMP_W-1:0] amp
);
    // R4
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R4
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R5
    amp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (amp == '0));

    // R9
    amp_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (amp >= 0));

    // R9
    peak_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (amp != '0) |=> (amp == '0));

endmodule

bind phx_pulse_height phx_pulse_height_chk #(.AMP_W(AMP_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .out_valid(amp_valid),
    .amp      (amp)
);

// File: tb/phx_pulse_height_tb_top.sv
// Bench: behavioural model with a sample history queue, compared each clock.
module phx_pulse_height_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [31:0]        in_sample = '0;
    logic               amp_valid;
    logic signed [21:0] amp;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // model state
    int hist[$];
    int m_last, m_valley, m_dir;
    bit exp_valid;
    int exp_amp;
    int max_amp;
    int lcg = 12345;

    phx_pulse_height dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sample(in_sample),
        .amp_valid(amp_valid),
        .amp      (amp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic model_reset();
        hist.delete();
        for (int i = 0; i < 20; i++) hist.push_back(0);
        m_last = 0; m_valley = 0; m_dir = 0;
        exp_valid = 0; exp_amp = 0;
    endtask

    // Behavioural step of the model for one accepted sample.
    task automatic model_sample(input logic [31:0] s);
        int v, s1, s2, shp;
        v = int'($signed(s[31:16]));
        hist.push_front(v);
        void'(hist.pop_back());
        s1 = 0; s2 = 0;
        for (int i = 0; i < 10; i++) s1 += hist[i];
        for (int i = 10; i < 20; i++) s2 += hist[i];
        shp = s1 - s2;
        exp_amp = 0;
        if (shp > m_last) begin
            if (m_dir == 2) m_valley = m_last;
            m_dir = 1;
        end else if (shp < m_last) begin
            if (m_dir == 1) exp_amp = m_last - m_valley;
            m_dir = 2;
        end
        m_last = shp;
        exp_valid = 1;
    endtask

    // One clock: check the result of the previous stimulus, then drive.
    task automatic step(input bit v, input logic [31:0] s);
        string tag;
        @(negedge clk);
        check("R4", int'(amp_valid), int'(exp_valid));
        if (!exp_valid) tag = "R5";
        else if (exp_amp != 0) tag = "R8";
        else tag = "R6";
        check(tag, int'(amp), exp_amp);
        if (amp < 0) begin
            checks++; errors++;
            $display("FAIL R9: actual %0d expected >= 0", amp);
        end
        if (amp_valid && int'(amp) > max_amp) max_amp = int'(amp);
        in_valid  = v;
        in_sample = s;
        if (v) model_sample(s);
        else begin exp_valid = 0; exp_amp = 0; end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; in_sample = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        // R1: outputs quiet after reset
        check("R1", int'(amp_valid), 0);
        check("R1", int'(amp), 0);
    endtask

    function automatic logic [31:0] mk(input int v, input int low);
        logic [31:0] r;
        r = {v[15:0], low[15:0]};
        return r;
    endfunction

    function automatic int rnd();
        lcg = lcg * 1103515245 + 12345;
        return (lcg >>> 8) & 32'h7fff;
    endfunction

    initial begin
        model_reset();
        do_reset();

        // R3: step of 100 gives peak of 10 * 100 above zero valley
        max_amp = 0;
        for (int i = 0; i < 25; i++) step(1, mk(100, 0));
        for (int i = 0; i < 25; i++) step(1, mk(0, 0));
        check("R3", max_amp, 1000);

        // R2: same step with noisy lower half, after reset
        do_reset();
        max_amp = 0;
        for (int i = 0; i < 25; i++) step(1, mk(100, rnd()));
        for (int i = 0; i < 25; i++) step(1, mk(0, rnd() | 16'h8000));
        check("R2", max_amp, 1000);

        // R5: strobe gaps leave the result unchanged (same step, gapped)
        do_reset();
        max_amp = 0;
        for (int i = 0; i < 25; i++) begin
            step(1, mk(100, 0));
            step(0, mk(777, 0));
        end
        for (int i = 0; i < 25; i++) begin
            step(0, mk(-500, 0));
            step(1, mk(0, 0));
        end
        step(0, '0);
        check("R5", max_amp, 1000);

        // R7, R10: full-scale negative then positive step
        do_reset();
        max_amp = 0;
        for (int i = 0; i < 30; i++) step(1, mk(-32768, 0));
        for (int i = 0; i < 30; i++) step(1, mk(32767, 0));
        for (int i = 0; i < 5; i++) step(1, mk(32767, 0));
        check("R7,R10", max_amp, 983030);

        // R6, R8, R9: noisy pulse train with decaying tails and gaps
        do_reset();
        for (int p = 0; p < 40; p++) begin
            int a;
            a = 2000 + (rnd() & 16'h1fff);
            for (int k = 0; k < 40; k++) begin
                int noise;
                noise = (rnd() & 16'h3f) - 32;
                step((rnd() & 7) != 0, mk(a + noise, rnd()));
                a = a - (a >>> 3);
            end
        end

        // R1: reset in mid-stream restarts from zero history
        for (int i = 0; i < 7; i++) step(1, mk(3000, 0));
        do_reset();
        max_amp = 0;
        for (int i = 0; i < 25; i++) step(1, mk(50, 0));
        for (int i = 0; i < 5; i++) step(1, mk(0, 0));
        check("R1", max_amp, 500);

        // R6: plateaus of equal shaped values mixed with alternation
        for (int i = 0; i < 60; i++) step(1, mk((i % 6 < 3) ? 200 : -200, 0));
        step(0, '0);
        step(0, '0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule